// File: doc/BRIEF.md
# Prioritized Interrupt Pending Tracker

This block keeps the delivery state of 256 interrupt vectors in three bit maps: one for requests that wait for the processor, one for vectors the processor is servicing, and one for the trigger mode of each vector. A request names a vector and a trigger mode. While the controller is enabled, the request sets the vector's pending bit and records its trigger mode. The block derives the processor priority from a programmable task priority and the highest vector in service. It presents the highest pending vector to the processor only when that vector's priority class is above the processor priority.

The processor takes the offered vector through an acknowledge pulse, which moves the vector from pending to in service. An end-of-interrupt pulse retires the highest vector in service. One cycle later the block reports the retired vector to the upstream controller, together with whether it was level- or edge-triggered. The report is withheld when directed end-of-interrupt is enabled. The priority class of a vector is its upper nibble.

Top module: `itrk_top`

## Requirements
- R1: After reset all three bit maps are zero, the task priority and processor priority are 0, no interrupt is offered, the pending flag is low and no end-of-interrupt report is valid.
- R2: The processor priority equals the full 8-bit task priority when task priority bits [7:4] are at least bits [7:4] of the highest in-service vector (0 when nothing is in service). Otherwise it equals that in-service vector with bits [3:0] cleared. A task priority write takes effect on the following cycle.
- R3: `int_valid` is high exactly when the controller is enabled, some vector is pending, and the highest pending vector with bits [3:0] cleared is strictly greater than the processor priority. `int_vector` then carries that highest pending vector. Vectors 0 to 15 can therefore never be offered while the processor priority is 0 or above.
- R4: An accepted request sets the vector's pending bit and sets (level, `req_level`=1) or clears (edge) its trigger-mode bit at the next edge. `req_new` is high when the pending bit was clear. `req_dup` is high when it was already set, and the request is then reported as discarded.
- R5: The controller is enabled only when both `hw_en` and `sw_en` are high. While it is disabled, requests change no bit map, `req_new` and `req_dup` stay low, and nothing is offered.
- R6: An acknowledge while `int_valid` is high sets the offered vector's in-service bit and clears its pending bit at the next edge. An acknowledge while `int_valid` is low has no effect.
- R7: An end-of-interrupt pulse with a vector in service clears the highest in-service bit and its trigger-mode bit. In the next cycle it raises `eoi_out_valid` with that vector and `eoi_out_level` equal to the trigger-mode bit before clearing (1 = level).
- R8: An end-of-interrupt pulse while nothing is in service changes no state and produces no report.
- R9: With `eoi_direct` high, an end-of-interrupt pulse still retires the vector but produces no report.
- R10: `pend_any` is high exactly when at least one pending bit is set.
- R11: In a cycle with both an acknowledge and a request for the same vector, the acknowledge is applied first. The request counts as new, and the vector ends the cycle both pending and in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_en | input | 1 | Hardware enable of the controller |
| sw_en | input | 1 | Software enable of the controller |
| eoi_direct | input | 1 | Directed end-of-interrupt: suppresses the upstream report |
| req_valid | input | 1 | Fixed-mode interrupt request strobe |
| req_vector | input | 8 | Requested vector |
| req_level | input | 1 | Requested trigger mode, 1 = level, 0 = edge |
| req_new | output | 1 | Request accepted into a clear pending bit |
| req_dup | output | 1 | Request discarded, vector already pending |
| tpr_we | input | 1 | Task priority write strobe |
| tpr_wdata | input | 8 | Task priority write value |
| tpr | output | 8 | Current task priority |
| ppr | output | 8 | Current processor priority |
| int_valid | output | 1 | A deliverable vector is offered |
| int_vector | output | 8 | Offered vector |
| ack | input | 1 | Processor acknowledge of the offered vector |
| eoi_we | input | 1 | End-of-interrupt strobe |
| eoi_out_valid | output | 1 | Retirement report valid (one cycle) |
| eoi_out_vector | output | 8 | Retired vector |
| eoi_out_level | output | 1 | Retired vector was level-triggered |
| pend_any | output | 1 | At least one vector pending |
| pend_map | output | 256 | Pending bit map, bit n = vector n |
| svc_map | output | 256 | In-service bit map, bit n = vector n |
| trig_map | output | 256 | Trigger-mode bit map, bit n = vector n |

## Verification
The assertions assume that every input is a known value sampled at the rising edge and that `ack` and `eoi_we` are single-cycle strobes. They also rely on the block's own guarantee that an acknowledged vector always belongs to a class above every vector in service, so an acknowledge and an end-of-interrupt in the same cycle never touch the same bit. The stimulus changes every input on the falling edge. It combines directed sequences at the priority boundaries with a long random phase. Vectors in the random phase are drawn so that duplicates, same-cycle acknowledge and request, and end-of-interrupt with an empty in-service map all occur.

// File: rtl/itrk_pkg.sv
package itrk_pkg;
  localparam int VEC_W   = 8;
  localparam int NUM_VEC = 1 << VEC_W;
  localparam int CLS_W   = 4;

  typedef logic [VEC_W-1:0]   vec_t;
  typedef logic [NUM_VEC-1:0] map_t;

  // clear the sub-class bits of a vector
  function automatic vec_t class_floor(vec_t v);
    return {v[VEC_W-1 -: CLS_W], {(VEC_W-CLS_W){1'b0}}};
  endfunction

  // processor priority from task priority and top in-service vector
  function automatic vec_t proc_prio(vec_t task_p, logic svc_found, vec_t svc_top);
    vec_t s;
    s = svc_found ? svc_top : '0;
    if (task_p[VEC_W-1 -: CLS_W] >= s[VEC_W-1 -: CLS_W]) return task_p;
    return class_floor(s);
  endfunction

  // a pending vector may be offered only above the processor priority
  function automatic logic above_prio(vec_t top, vec_t prio);
    return class_floor(top) > prio;
  endfunction
endpackage

// File: rtl/itrk_prio_enc.sv
module itrk_prio_enc #(
  parameter int W  = 256,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  map,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < W; i++) begin
      if (map[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/itrk_vec_bank.sv
module itrk_vec_bank #(
  parameter int NV = 256,
  localparam int IW = $clog2(NV)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_fire,
  input  logic [IW-1:0] set_vec,
  input  logic          set_lvl,
  input  logic          ack_fire,
  input  logic [IW-1:0] ack_vec,
  input  logic          eoi_fire,
  input  logic [IW-1:0] eoi_vec,
  output logic [NV-1:0] pend,
  output logic [NV-1:0] svc,
  output logic [NV-1:0] trig,
  output logic          pend_any
);
  logic [NV-1:0] pend_n, svc_n, trig_n;

  always_comb begin
    pend_n = pend;
    svc_n  = svc;
    trig_n = trig;
    if (ack_fire) begin
      pend_n[ack_vec] = 1'b0;
      svc_n[ack_vec]  = 1'b1;
    end
    if (eoi_fire) begin
      svc_n[eoi_vec]  = 1'b0;
      trig_n[eoi_vec] = 1'b0;
    end
    if (set_fire) begin
      trig_n[set_vec] = set_lvl;
      pend_n[set_vec] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= '0;
      svc      <= '0;
      trig     <= '0;
      pend_any <= 1'b0;
    end else begin
      pend     <= pend_n;
      svc      <= svc_n;
      trig     <= trig_n;
      pend_any <= |pend_n;
    end
  end
endmodule

// File: rtl/itrk_arbiter.sv
module itrk_arbiter
  import itrk_pkg::*;
(
  input  logic enabled,
  input  vec_t task_p,
  input  logic svc_found,
  input  vec_t svc_top,
  input  logic pend_found,
  input  vec_t pend_top,
  output vec_t ppr,
  output logic offer,
  output vec_t offer_vec
);
  always_comb begin
    ppr       = proc_prio(task_p, svc_found, svc_top);
    offer     = enabled && pend_found && above_prio(pend_top, ppr);
    offer_vec = pend_top;
  end
endmodule

// File: rtl/itrk_top.sv
module itrk_top
  import itrk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hw_en,
  input  logic               sw_en,
  input  logic               eoi_direct,
  input  logic               req_valid,
  input  logic [VEC_W-1:0]   req_vector,
  input  logic               req_level,
  output logic               req_new,
  output logic               req_dup,
  input  logic               tpr_we,
  input  logic [VEC_W-1:0]   tpr_wdata,
  output logic [VEC_W-1:0]   tpr,
  output logic [VEC_W-1:0]   ppr,
  output logic               int_valid,
  output logic [VEC_W-1:0]   int_vector,
  input  logic               ack,
  input  logic               eoi_we,
  output logic               eoi_out_valid,
  output logic [VEC_W-1:0]   eoi_out_vector,
  output logic               eoi_out_level,
  output logic               pend_any,
  output logic [NUM_VEC-1:0] pend_map,
  output logic [NUM_VEC-1:0] svc_map,
  output logic [NUM_VEC-1:0] trig_map
);
  // named internal events
  logic enabled, accept_fire, ack_fire, eoi_fire;
  logic pend_found, svc_found;
  vec_t pend_top, svc_top;
  logic same_vec;

  itrk_prio_enc #(.W(NUM_VEC)) u_pend_enc (.map(pend_map), .found(pend_found), .idx(pend_top));
  itrk_prio_enc #(.W(NUM_VEC)) u_svc_enc  (.map(svc_map),  .found(svc_found),  .idx(svc_top));

  itrk_arbiter u_arb (
    .enabled(enabled), .task_p(tpr), .svc_found(svc_found), .svc_top(svc_top),
    .pend_found(pend_found), .pend_top(pend_top),
    .ppr(ppr), .offer(int_valid), .offer_vec(int_vector)
  );

  assign enabled     = hw_en && sw_en;
  assign accept_fire = req_valid && enabled;
  assign ack_fire    = ack && int_valid;
  assign eoi_fire    = eoi_we && svc_found;
  assign same_vec    = ack_fire && (int_vector == req_vector);
  assign req_dup     = accept_fire && pend_map[req_vector] && !same_vec;
  assign req_new     = accept_fire && !req_dup;

  itrk_vec_bank #(.NV(NUM_VEC)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .set_fire(accept_fire), .set_vec(req_vector), .set_lvl(req_level),
    .ack_fire(ack_fire), .ack_vec(int_vector),
    .eoi_fire(eoi_fire), .eoi_vec(svc_top),
    .pend(pend_map), .svc(svc_map), .trig(trig_map), .pend_any(pend_any)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tpr            <= '0;
      eoi_out_valid  <= 1'b0;
      eoi_out_vector <= '0;
      eoi_out_level  <= 1'b0;
    end else begin
      if (tpr_we) tpr <= tpr_wdata;
      eoi_out_valid <= eoi_fire && !eoi_direct;
      if (eoi_fire) begin
        eoi_out_vector <= svc_top;
        eoi_out_level  <= trig_map[svc_top];
      end
    end
  end
endmodule

// File: rtl/itrk_checker.sv
module itrk_checker
  import itrk_pkg::*;
(
  input logic         clk,
  input logic         rst_n,
  input logic         hw_en,
  input logic         sw_en,
  input logic         eoi_direct,
  input logic         eoi_we,
  input logic         req_new,
  input logic         req_dup,
  input logic         int_valid,
  input vec_t         int_vector,
  input vec_t         tpr,
  input vec_t         ppr,
  input logic         ack_fire,
  input logic         eoi_out_valid,
  input vec_t         eoi_out_vector,
  input logic         pend_any,
  input logic [NUM_VEC-1:0] pend_map,
  input logic [NUM_VEC-1:0] svc_map
);
  p_ppr_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ppr >= tpr);

  p_offer_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int_valid |-> pend_map[int_vector] && hw_en && sw_en);

  p_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(hw_en && sw_en) |-> !req_new && !req_dup && !int_valid);

  p_ack_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> svc_map[$past(int_vector)]);

  p_retired_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_out_valid |-> !svc_map[eoi_out_vector]);

  p_eoi_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_we && svc_map == '0) |=> !eoi_out_valid);

  p_directed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_direct |=> !eoi_out_valid);

  p_pend_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pend_any == (pend_map != '0));
endmodule

bind itrk_top itrk_checker u_itrk_checker (
  .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .sw_en(sw_en),
  .eoi_direct(eoi_direct), .eoi_we(eoi_we),
  .req_new(req_new), .req_dup(req_dup),
  .int_valid(int_valid), .int_vector(int_vector), .tpr(tpr), .ppr(ppr),
  .ack_fire(ack_fire), .eoi_out_valid(eoi_out_valid),
  .eoi_out_vector(eoi_out_vector), .pend_any(pend_any),
  .pend_map(pend_map), .svc_map(svc_map)
);

// File: tb/tb_itrk_top.sv
module tb_itrk_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hw_en = 0, sw_en = 0, eoi_direct = 0;
  logic req_valid = 0, req_level = 0, tpr_we = 0, ack = 0, eoi_we = 0;
  logic [7:0] req_vector = 0, tpr_wdata = 0;
  logic req_new, req_dup, int_valid, eoi_out_valid, eoi_out_level, pend_any;
  logic [7:0] tpr, ppr, int_vector, eoi_out_vector;
  logic [255:0] pend_map, svc_map, trig_map;

  always #5 clk = ~clk;

  itrk_top dut (.*);

  int total = 0, fails = 0;
  bit done = 0;

  // reference state
  logic [255:0] m_pend = 0, m_svc = 0, m_trig = 0;
  int m_tpr = 0;
  bit m_nv = 0, m_nlvl = 0;
  int m_nvec = 0;

  task automatic chk(string tag, logic [255:0] got, logic [255:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic int top_of(logic [255:0] m);
    for (int i = 255; i >= 0; i--) if (m[i]) return i;
    return -1;
  endfunction

  function automatic int m_ppr();
    int s;
    s = (top_of(m_svc) < 0) ? 0 : top_of(m_svc);
    return (m_tpr / 16 >= s / 16) ? m_tpr : (s / 16) * 16;
  endfunction

  function automatic bit m_offer();
    int h;
    h = top_of(m_pend);
    return hw_en && sw_en && h >= 0 && (h / 16) * 16 > m_ppr();
  endfunction

  task automatic compare();
    bit en, dup, nw;
    en  = hw_en && sw_en;
    dup = req_valid && en && m_pend[req_vector] &&
          !(ack && m_offer() && top_of(m_pend) == int'(req_vector));
    nw  = req_valid && en && !dup;
    chk("R4 pend_map", pend_map, m_pend);
    chk("R6 svc_map", svc_map, m_svc);
    chk("R4 trig_map", trig_map, m_trig);
    chk("R2 ppr", 256'(ppr), 256'(m_ppr()));
    chk("R2 tpr", 256'(tpr), 256'(m_tpr));
    chk("R3 int_valid", 256'(int_valid), 256'(m_offer()));
    if (m_offer()) chk("R3 int_vector", 256'(int_vector), 256'(top_of(m_pend)));
    chk("R4 req_new", 256'(req_new), 256'(nw));
    chk("R4 req_dup", 256'(req_dup), 256'(dup));
    chk("R10 pend_any", 256'(pend_any), 256'(m_pend != 0));
    chk("R7 eoi_out_valid", 256'(eoi_out_valid), 256'(m_nv));
    if (m_nv) begin
      chk("R7 eoi_out_vector", 256'(eoi_out_vector), 256'(m_nvec));
      chk("R7 eoi_out_level", 256'(eoi_out_level), 256'(m_nlvl));
    end
  endtask

  task automatic model_update();
    bit ackf, eoif, lvl;
    int av, sv;
    ackf = ack && m_offer();
    av   = top_of(m_pend);
    sv   = top_of(m_svc);
    eoif = eoi_we && sv >= 0;
    lvl  = eoif ? m_trig[sv] : 1'b0;
    if (ackf) begin m_pend[av] = 0; m_svc[av] = 1; end
    if (eoif) begin m_svc[sv] = 0; m_trig[sv] = 0; end
    if (req_valid && hw_en && sw_en) begin
      m_trig[req_vector] = req_level;
      m_pend[req_vector] = 1;
    end
    if (tpr_we) m_tpr = tpr_wdata;
    m_nv = eoif && !eoi_direct;
    if (eoif) begin m_nvec = sv; m_nlvl = lvl; end
  endtask

  // inputs were set at a falling edge; compare, advance one clock
  task automatic step();
    #1 compare();
    @(posedge clk);
    model_update();
    @(negedge clk);
    req_valid = 0; ack = 0; eoi_we = 0; tpr_we = 0;
  endtask

  task automatic req(int v, bit lvl);
    req_valid = 1; req_vector = 8'(v); req_level = lvl;
  endtask

  task automatic set_tpr(int v);
    tpr_we = 1; tpr_wdata = 8'(v); step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 pend_map", pend_map, 0);
    chk("R1 svc_map", svc_map, 0);
    chk("R1 ppr", 256'(ppr), 0);
    chk("R1 int_valid", 256'(int_valid), 0);
    chk("R1 pend_any", 256'(pend_any), 0);
    chk("R1 eoi_out_valid", 256'(eoi_out_valid), 0);
    rst_n = 1;
    @(negedge clk);

    // R5: one enable alone is not enough
    hw_en = 1; sw_en = 0; req(8'h40, 0); #1 chk("R5 req_new", 256'(req_new), 0); step();
    chk("R5 pend_map", pend_map, 0);
    hw_en = 0; sw_en = 1; req(8'h40, 1); step();
    chk("R5 pend_map", pend_map, 0);
    hw_en = 1;

    // R4: accept, level marking, duplicate
    req(8'h31, 0); step();
    req(8'h52, 1); step();
    chk("R4 trig bit", 256'(trig_map[8'h52]), 1);
    req(8'h52, 1); #1 chk("R4 dup", 256'(req_dup), 1); step();
    chk("R3 top vector", 256'(int_vector), 256'(8'h52));

    // R3: class boundary against task priority
    set_tpr(8'h50); chk("R3 equal class blocked", 256'(int_valid), 0);
    set_tpr(8'h4F); chk("R3 above ppr", 256'(int_valid), 1);
    set_tpr(0);

    // R6 / R2
    ack = 1; step();
    chk("R2 ppr from svc", 256'(ppr), 256'(8'h50));
    chk("R3 lower class held", 256'(int_valid), 0);
    ack = 1; step();
    chk("R6 ack ignored", svc_map, 256'(1) << 8'h52);
    req(8'h95, 0); step();
    ack = 1; step();
    chk("R2 ppr 0x90", 256'(ppr), 256'(8'h90));
    set_tpr(8'hA3); chk("R2 ppr tpr", 256'(ppr), 256'(8'hA3));
    set_tpr(0);

    // R7 / R8
    eoi_we = 1; step();
    chk("R7 vec edge", 256'({eoi_out_valid, eoi_out_vector, eoi_out_level}), 256'({1'b1, 8'h95, 1'b0}));
    eoi_we = 1; step();
    chk("R7 vec level", 256'({eoi_out_valid, eoi_out_vector, eoi_out_level}), 256'({1'b1, 8'h52, 1'b1}));
    chk("R7 trig cleared", 256'(trig_map[8'h52]), 0);
    eoi_we = 1; step();
    chk("R8 no report", 256'(eoi_out_valid), 0);

    // R9
    eoi_direct = 1; ack = 1; step();
    eoi_we = 1; step();
    chk("R9 suppressed", 256'(eoi_out_valid), 0);
    chk("R9 retired", svc_map, 0);
    eoi_direct = 0;

    // R11: ack and request of the same vector
    req(8'h31, 0); step();
    ack = 1; req(8'h31, 1); #1 chk("R11 new", 256'(req_new), 1); step();
    chk("R11 both", 256'({pend_map[8'h31], svc_map[8'h31]}), 256'(2'b11));
    eoi_we = 1; step();
    ack = 1; step();
    eoi_we = 1; step();
    chk("R10 empty", 256'(pend_any), 0);
    req(8'h0A, 0); step();
    chk("R10 set", 256'(pend_any), 1);
    chk("R3 low vector never offered", 256'(int_valid), 0);

    // random phase against the reference
    for (int n = 0; n < 3000; n++) begin
      hw_en      = ($urandom % 16) != 0;
      sw_en      = ($urandom % 16) != 0;
      eoi_direct = ($urandom % 4) == 0;
      req_valid  = $urandom % 2;
      req_vector = ($urandom % 2) ? 8'(8'h30 + $urandom % 8 * 16 + $urandom % 3) : 8'($urandom);
      req_level  = $urandom % 2;
      ack        = ($urandom % 3) == 0;
      eoi_we     = ($urandom % 4) == 0;
      tpr_we     = ($urandom % 10) == 0;
      tpr_wdata  = 8'($urandom % 160);
      step();
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule